// File: doc/BRIEF.md
# Double-Buffered Event Code Sequencer

This block produces the per-clock event code stream of a timing master. It runs on the event clock derived from the RF reference and is started by a 360 Hz fiducial pulse. Two banks of sequence storage hold entries of the form (clock offset, event code). One bank plays out while the host loads the other. At a fiducial the banks exchange roles, provided the host has committed the loaded bank.

Every cycle starts with a fixed fiducial code. Four timestamp events follow it, carrying the 32-bit pulse ID one byte at a time on a side data byte. The entries of the active bank come after the timestamp. On every clock with nothing scheduled, the idle code is driven.

Host loading uses a valid/ready write port. A beat is accepted on a clock where `wr_valid` and `wr_ready` are both high. `wr_ready` drops only on a clock where `fiducial` is high, because the bank roles change on that edge. The host must hold the beat until it sees `wr_ready` high. The event output cannot be stalled, since the link consumes one code per clock. The fiducial, commit and status pins are plain level/pulse signals.

Top module: `event_sequencer`

## Requirements
- R1: After reset, `evt_code` is 0x00, `evt_data` is 0x00, `active_bank` is 0, `underrun` is 0 and `wr_ready` is 1.
- R2: On the clock after `fiducial` is sampled high, `evt_code` equals the fiducial code (parameter, default 0x7D), and `evt_data` is 0x00.
- R3: On the four clocks after the fiducial code, `evt_code` is 0x70, 0x71, 0x72 and 0x73 in that order. The matching `evt_data` bytes are `pulse_id` bits [7:0], [15:8], [23:16] and [31:24], with `pulse_id` captured on the fiducial clock.
- R4: Entries are stored as {offset, code}, with the code in the low 8 bits of the write data. They are read from address 0 upward. An entry with offset k is emitted on output clock 5+k, counting the fiducial code clock as clock 0. Every other clock carries code 0x00 with `evt_data` 0x00.
- R5: If an entry's offset is already reached or passed when that entry comes up, it is emitted on that clock. Entries with equal offsets therefore come out on consecutive clocks.
- R6: An entry whose code is 0x7F ends playout. 0x7F itself never appears on `evt_code`, and only the idle code follows until the next fiducial.
- R7: Writes always go to the bank that is not playing, and never change what the playing bank emits. `wr_ready` is low on a clock where `fiducial` is high.
- R8: If a commit was seen since the last swap, or `commit` is high on the fiducial clock, the fiducial toggles `active_bank` and playout uses the newly loaded bank. `active_bank` changes on no other clock.
- R9: If no commit is pending at a fiducial, the banks do not swap and the previous bank is replayed. `underrun` is set and stays set until reset.
- R10: A fiducial that arrives during playout restarts the cycle from the fiducial code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fiducial | input | 1 | One-clock pulse starting a cycle |
| pulse_id | input | 32 | Pulse ID to be stamped, sampled on the fiducial clock |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Write beat accepted when high with wr_valid |
| wr_addr | input | AW (10) | Entry address in the loading bank |
| wr_offset | input | OFS_W (20) | Entry clock offset |
| wr_code | input | 8 | Entry event code |
| commit | input | 1 | Pulse: the loading bank is complete |
| evt_code | output | 8 | Event code for this clock |
| evt_data | output | 8 | Timestamp byte beside codes 0x70 to 0x73, else 0 |
| active_bank | output | 1 | Bank currently playing |
| underrun | output | 1 | Sticky: a fiducial found no committed bank |

## Verification
The bench targets the exact clock positions of the timestamp bytes and the scheduled entries. A design with a miscounted pipeline stage would shift every entry by one slot, and one that sends the bytes in the wrong order would scramble the pulse ID. Two entries with the same offset are loaded to catch a sequencer that waits for strict equality; such a design would swallow the second code forever. A cycle with no commit checks that the old bank is replayed and that the underrun flag latches and stays set. A design that swapped anyway would play the half-loaded bank. A fiducial that arrives during playout checks the restart, and the end marker is checked so that it never leaks onto the output.

// File: rtl/evseq_pkg.sv
package evseq_pkg;
  localparam logic [7:0] CODE_IDLE    = 8'h00;
  localparam logic [7:0] CODE_END     = 8'h7F;
  localparam logic [7:0] CODE_TS_BASE = 8'h70;
  localparam int         TS_BYTES     = 4;

  typedef enum logic [1:0] {
    PL_IDLE  = 2'd0,
    PL_STAMP = 2'd1,
    PL_PLAY  = 2'd2
  } play_state_e;
endpackage

// File: rtl/evseq_bank.sv
module evseq_bank #(
  parameter int AW = 10,
  parameter int DW = 28
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/evseq_bank_ctrl.sv
module evseq_bank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fiducial,
  input  logic commit,
  output logic active,
  output logic underrun
);
  logic ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      ready_q  <= 1'b0;
      underrun <= 1'b0;
    end else if (fiducial) begin
      if (ready_q || commit) begin
        active  <= ~active;
        ready_q <= 1'b0;
      end else begin
        underrun <= 1'b1;
      end
    end else if (commit) begin
      ready_q <= 1'b1;
    end
  end
endmodule

// File: rtl/evseq_player.sv
module evseq_player
  import evseq_pkg::*;
#(
  parameter int         AW       = 10,
  parameter int         OFS_W    = 20,
  parameter logic [7:0] FID_CODE = 8'h7D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fiducial,
  input  logic [31:0]      pulse_id,
  input  logic [OFS_W-1:0] entry_ofs,
  input  logic [7:0]       entry_code,
  output logic [AW-1:0]    rd_addr,
  output logic [7:0]       evt_code,
  output logic [7:0]       evt_data
);
  localparam logic [AW-1:0]    LAST_ADDR = '1;
  localparam logic [OFS_W-1:0] CNT_MAX   = '1;
  localparam logic [1:0]       LAST_SLOT = 2'(TS_BYTES - 1);

  play_state_e      state;
  logic [1:0]       slot;
  logic [OFS_W-1:0] cnt;
  logic [31:0]      pid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PL_IDLE;
      slot     <= '0;
      cnt      <= '0;
      rd_addr  <= '0;
      pid_q    <= '0;
      evt_code <= CODE_IDLE;
      evt_data <= 8'h00;
    end else if (fiducial) begin
      state    <= PL_STAMP;
      slot     <= '0;
      cnt      <= '0;
      rd_addr  <= '0;
      pid_q    <= pulse_id;
      evt_code <= FID_CODE;
      evt_data <= 8'h00;
    end else begin
      case (state)
        PL_STAMP: begin
          evt_code <= CODE_TS_BASE + {6'd0, slot};
          evt_data <= pid_q[{slot, 3'b000} +: 8];
          slot     <= slot + 2'd1;
          if (slot == LAST_SLOT) state <= PL_PLAY;
        end
        PL_PLAY: begin
          evt_data <= 8'h00;
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (entry_code == CODE_END) begin
            evt_code <= CODE_IDLE;
            state    <= PL_IDLE;
          end else if (entry_ofs <= cnt) begin
            evt_code <= entry_code;
            if (rd_addr == LAST_ADDR) state <= PL_IDLE;
            else rd_addr <= rd_addr + 1'b1;
          end else begin
            evt_code <= CODE_IDLE;
          end
        end
        default: begin
          evt_code <= CODE_IDLE;
          evt_data <= 8'h00;
        end
      endcase
    end
  end
endmodule

// File: rtl/event_sequencer.sv
module event_sequencer
  import evseq_pkg::*;
#(
  parameter int         AW       = 10,
  parameter int         OFS_W    = 20,
  parameter logic [7:0] FID_CODE = 8'h7D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fiducial,
  input  logic [31:0]      pulse_id,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [OFS_W-1:0] wr_offset,
  input  logic [7:0]       wr_code,
  input  logic             commit,
  output logic [7:0]       evt_code,
  output logic [7:0]       evt_data,
  output logic             active_bank,
  output logic             underrun
);
  localparam int DW     = OFS_W + 8;
  localparam int NBANKS = 2;

  logic [AW-1:0] rd_addr;
  logic [DW-1:0] bank_rdata [NBANKS];
  logic [DW-1:0] cur_entry;
  logic          wr_fire;

  assign wr_ready = ~fiducial;
  assign wr_fire  = wr_valid & wr_ready;

  evseq_bank_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fiducial (fiducial),
    .commit   (commit),
    .active   (active_bank),
    .underrun (underrun)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    evseq_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk   (clk),
      .we    (wr_fire && (active_bank != b[0])),
      .waddr (wr_addr),
      .wdata ({wr_offset, wr_code}),
      .raddr (rd_addr),
      .rdata (bank_rdata[b])
    );
  end

  assign cur_entry = bank_rdata[active_bank];

  evseq_player #(.AW(AW), .OFS_W(OFS_W), .FID_CODE(FID_CODE)) u_player (
    .clk        (clk),
    .rst_n      (rst_n),
    .fiducial   (fiducial),
    .pulse_id   (pulse_id),
    .entry_ofs  (cur_entry[DW-1:8]),
    .entry_code (cur_entry[7:0]),
    .rd_addr    (rd_addr),
    .evt_code   (evt_code),
    .evt_data   (evt_data)
  );
endmodule

// File: rtl/evseq_checks.sv
module evseq_checks
  import evseq_pkg::*;
#(
  parameter logic [7:0] FID_CODE = 8'h7D
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fiducial,
  input logic [7:0] evt_code,
  input logic [7:0] evt_data,
  input logic       active_bank,
  input logic       underrun
);
  assert_fid_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fiducial |=> (evt_code == FID_CODE));

  assert_stamp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fiducial |=> ##1 (fiducial || evt_code == CODE_TS_BASE));

  assert_idle_data_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_code == CODE_IDLE) |-> (evt_data == 8'h00));

  assert_no_end_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_code != CODE_END);

  assert_bank_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fiducial |=> $stable(active_bank));

  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(underrun));

  assert_underrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(fiducial));
endmodule

bind event_sequencer evseq_checks #(.FID_CODE(FID_CODE)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .fiducial    (fiducial),
  .evt_code    (evt_code),
  .evt_data    (evt_data),
  .active_bank (active_bank),
  .underrun    (underrun)
);

// File: tb/event_sequencer_bench.sv
module event_sequencer_bench;
  localparam int AW    = 10;
  localparam int OFS_W = 20;
  localparam logic [7:0] FID = 8'h7D;
  localparam int MAXS  = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fiducial = 1'b0;
  logic [31:0]      pulse_id = '0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [AW-1:0]    wr_addr = '0;
  logic [OFS_W-1:0] wr_offset = '0;
  logic [7:0]       wr_code = '0;
  logic             commit = 1'b0;
  logic [7:0]       evt_code;
  logic [7:0]       evt_data;
  logic             active_bank;
  logic             underrun;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] cap_c [MAXS];
  logic [7:0] cap_d [MAXS];
  logic [7:0] exp_c [MAXS];
  logic [7:0] exp_d [MAXS];
  string      exp_r [MAXS];

  always #4 clk = ~clk;

  event_sequencer #(.AW(AW), .OFS_W(OFS_W), .FID_CODE(FID)) u_event_sequencer (
    .clk(clk), .rst_n(rst_n), .fiducial(fiducial), .pulse_id(pulse_id),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_offset(wr_offset), .wr_code(wr_code), .commit(commit),
    .evt_code(evt_code), .evt_data(evt_data),
    .active_bank(active_bank), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic wr_entry(input int a, input int ofs, input logic [7:0] code);
    @(negedge clk);
    wr_valid  = 1'b1;
    wr_addr   = AW'(a);
    wr_offset = OFS_W'(ofs);
    wr_code   = code;
    @(negedge clk);
    wr_valid  = 1'b0;
  endtask

  task automatic commit_bank();
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  // expected trace: fiducial code, four stamp bytes, idle elsewhere
  task automatic expect_base(input logic [31:0] pid);
    for (int s = 0; s < MAXS; s++) begin
      exp_c[s] = 8'h00; exp_d[s] = 8'h00; exp_r[s] = "R4";
    end
    exp_c[0] = FID; exp_r[0] = "R2";
    for (int i = 0; i < 4; i++) begin
      exp_c[1+i] = 8'h70 + 8'(i);
      exp_d[1+i] = pid[i*8 +: 8];
      exp_r[1+i] = "R3";
    end
  endtask

  task automatic fire_capture(input logic [31:0] pid, input int n);
    @(negedge clk);
    fiducial = 1'b1;
    pulse_id = pid;
    #1;
    chk(wr_ready == 1'b0, "R7", "wr_ready during fiducial", 32'(wr_ready), 0);
    @(negedge clk);
    fiducial = 1'b0;
    for (int s = 0; s < n; s++) begin
      cap_c[s] = evt_code;
      cap_d[s] = evt_data;
      if (s < n - 1) @(negedge clk);
    end
  endtask

  task automatic check_trace(input int n);
    for (int s = 0; s < n; s++) begin
      chk(cap_c[s] == exp_c[s], exp_r[s], $sformatf("code slot %0d", s), 32'(cap_c[s]), 32'(exp_c[s]));
      chk(cap_d[s] == exp_d[s], exp_r[s], $sformatf("data slot %0d", s), 32'(cap_d[s]), 32'(exp_d[s]));
    end
  endtask

  task automatic t_reset();
    chk(evt_code == 8'h00, "R1", "reset code", 32'(evt_code), 0);
    chk(evt_data == 8'h00, "R1", "reset data", 32'(evt_data), 0);
    chk(active_bank == 1'b0, "R1", "reset bank", 32'(active_bank), 0);
    chk(underrun == 1'b0, "R1", "reset underrun", 32'(underrun), 0);
    chk(wr_ready == 1'b1, "R1", "reset wr_ready", 32'(wr_ready), 1);
  endtask

  // R4 R5 R6 R8: load bank 1, commit, play with equal offsets and end marker
  task automatic t_first_swap();
    wr_entry(0, 2, 8'h11);
    wr_entry(1, 2, 8'h12);
    wr_entry(2, 6, 8'h13);
    wr_entry(3, 0, 8'h7F);
    wr_entry(4, 0, 8'h44);
    commit_bank();
    fire_capture(32'hA1B2C3D4, 24);
    expect_base(32'hA1B2C3D4);
    exp_c[7] = 8'h11;
    exp_c[8] = 8'h12; exp_r[8] = "R5";
    exp_c[11] = 8'h13;
    for (int s = 12; s < 24; s++) exp_r[s] = "R6";
    check_trace(24);
    chk(active_bank == 1'b1, "R8", "bank after commit", 32'(active_bank), 1);
    chk(underrun == 1'b0, "R8", "no underrun", 32'(underrun), 0);
  endtask

  // R7 R9: load bank 0 without commit, old bank replays, underrun latches
  task automatic t_underrun();
    wr_entry(0, 1, 8'h21);
    wr_entry(1, 0, 8'h7F);
    fire_capture(32'h01020304, 16);
    expect_base(32'h01020304);
    exp_c[7] = 8'h11; exp_r[7] = "R9";
    exp_c[8] = 8'h12; exp_r[8] = "R7";
    exp_c[11] = 8'h13; exp_r[11] = "R9";
    check_trace(16);
    chk(active_bank == 1'b1, "R9", "bank kept", 32'(active_bank), 1);
    chk(underrun == 1'b1, "R9", "underrun set", 32'(underrun), 1);
  endtask

  // R8 R9: commit bank 0, swap back, underrun stays sticky
  task automatic t_swap_back();
    commit_bank();
    fire_capture(32'hFFEE0055, 12);
    expect_base(32'hFFEE0055);
    exp_c[6] = 8'h21; exp_r[6] = "R8";
    check_trace(12);
    chk(active_bank == 1'b0, "R8", "bank swapped back", 32'(active_bank), 0);
    chk(underrun == 1'b1, "R9", "underrun sticky", 32'(underrun), 1);
  endtask

  // R10: a fiducial in mid-playout restarts from the fiducial code
  task automatic t_restart();
    wr_entry(0, 20, 8'h31);
    wr_entry(1, 0, 8'h7F);
    commit_bank();
    fire_capture(32'h12345678, 10);
    expect_base(32'h12345678);
    check_trace(10);
    fire_capture(32'h9ABCDEF0, 30);
    expect_base(32'h9ABCDEF0);
    exp_r[0] = "R10";
    exp_c[25] = 8'h31; exp_r[25] = "R10";
    check_trace(30);
    chk(active_bank == 1'b1, "R8", "bank after restart", 32'(active_bank), 1);
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_swap();
    t_underrun();
    t_swap_back();
    t_restart();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule